// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the byte-wide front end that a host processor uses to program and read a three-channel interval timer. The host reaches it through a 2-bit address with separate write and read strobes. Addresses 0, 1 and 2 select the count register of channels 0, 1 and 2. Address 3 accepts control words. The block decodes each control word and keeps a per-channel configuration: the byte access scheme, the operating mode and the decimal-count flag. It assembles 16-bit start values from byte writes and hands each one to the channel's counter core as a one-cycle load strobe with the value.

For reads, the block takes in each counter core's live 16-bit count and output level. It can freeze a count snapshot or a status snapshot on command and returns bytes in the order the access scheme sets. A multi-channel latch command lets the host freeze counts, status or both on several channels with a single write. A frozen status byte is always returned before a frozen count. The counter cores are separate blocks that connect to the load and configuration outputs.

Top module: `tmr_host_if`

## Requirements
- R1: After reset, every channel uses the two-byte access scheme (low byte first, then high byte) with mode 0 and the decimal flag clear. No load strobe is active and the read data is 0x00.
- R2: A write to address 3 with bits 7:6 equal to a channel number and bits 5:4 nonzero stores the access scheme from bits 5:4 (1 = low byte only, 2 = high byte only, 3 = low then high). It also stores the mode from bits 3:1 and the decimal flag from bit 0. A mode code of 6 becomes 2 and a code of 7 becomes 3. The stored mode and flag appear on `mode_o` and `bcd_o` from the next cycle.
- R3: A byte written to a channel address in the low-only scheme loads {0x00, byte}. In the high-only scheme it loads {byte, 0x00}. The load strobe for that channel is high for exactly the one cycle after the write.
- R4: In the two-byte scheme, the first data write is held and produces no load. The second data write loads {second, first}. The following pairs repeat this pattern.
- R5: A control word that configures a channel returns that channel's write and read byte sequencing to the low byte.
- R6: A control word with bits 5:4 equal to 0 freezes the channel's live count. Later reads return the frozen bytes in the channel's access scheme. The snapshot is released after its last byte, and reads then return the live count again.
- R7: A count freeze on a channel whose frozen count is still unread has no effect. The same holds for a status freeze on a channel whose frozen status is still unread.
- R8: A control word with bits 7:6 equal to 3 is a multi-channel latch command. Bits 1, 2 and 3 select channels 0, 1 and 2. A 0 in bit 5 freezes the count and a 0 in bit 4 freezes the status of every selected channel.
- R9: A frozen status byte is {output level, 0, access scheme[1:0], mode[2:0], decimal flag}, from bit 7 down to bit 0. A channel read returns and releases a pending status byte before any frozen count.
- R10: With nothing frozen, reads in the two-byte scheme alternate between the low byte and the high byte of the live count. Reads in the single-byte schemes return the selected byte every time.
- R11: A read of address 3 returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register address: channel 0..2, or 3 for control |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; ignored while wr_en is high |
| wdata | input | 8 | Write data byte |
| rdata | output | 8 | Read data, registered, valid the cycle after rd_en |
| load_stb | output | 3 | Per-channel one-cycle count load strobe |
| load_val | output | 48 | Per-channel 16-bit start value, channel i at bits 16i+15:16i |
| mode_o | output | 9 | Per-channel mode, channel i at bits 3i+2:3i |
| bcd_o | output | 3 | Per-channel decimal-count flag |
| live_cnt | input | 48 | Per-channel live count from the counter cores |
| ch_out | input | 3 | Per-channel counter output level |

## Verification
Loads are tried in each of the three access schemes with distinct byte values. The results show whether the byte went to the low or the high half, and whether a two-byte pair was assembled in the right order. Frozen counts are read after the live count has been changed on purpose, so a returned frozen byte can be told apart from a live one. Repeated latch commands show whether the first snapshot was kept. The multi-channel command is given with different output levels and configurations on each channel. Each status byte is then unique, and the read order shows whether the status byte came before the count.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int CNT_W  = 16;
  localparam int BYTE_W = 8;
  localparam int MODE_W = 3;

  typedef enum logic [1:0] {
    ACC_LATCH = 2'd0,
    ACC_LO    = 2'd1,
    ACC_HI    = 2'd2,
    ACC_WORD  = 2'd3
  } acc_t;

  // Codes 6 and 7 fold onto 2 and 3.
  function automatic logic [MODE_W-1:0] fold_mode(input logic [MODE_W-1:0] m);
    return (m[2] && m[1]) ? {1'b0, m[1:0]} : m;
  endfunction
endpackage

// File: rtl/tmr_ctrl_decode.sv
module tmr_ctrl_decode
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic [AW-1:0]     addr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wdata,
  output logic [NCH-1:0]    cfg_we,
  output logic [NCH-1:0]    cnt_lat,
  output logic [NCH-1:0]    st_lat,
  output logic [NCH-1:0]    data_we,
  output acc_t              cfg_acc,
  output logic [MODE_W-1:0] cfg_mode,
  output logic              cfg_bcd
);
  localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

  logic       ctl;
  logic       multi;
  logic [1:0] sel;

  assign ctl      = wr_en && (addr == CTRL_ADDR);
  assign sel      = wdata[7:6];
  assign multi    = (sel == 2'd3);
  assign cfg_acc  = acc_t'(wdata[5:4]);
  assign cfg_mode = fold_mode(wdata[3:1]);
  assign cfg_bcd  = wdata[0];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    logic hit;
    assign hit        = ctl && !multi && (sel == 2'(i));
    assign cfg_we[i]  = hit && (cfg_acc != ACC_LATCH);
    assign cnt_lat[i] = (hit && (cfg_acc == ACC_LATCH)) ||
                        (ctl && multi && wdata[i+1] && !wdata[5]);
    assign st_lat[i]  = ctl && multi && wdata[i+1] && !wdata[4];
    assign data_we[i] = wr_en && (addr == AW'(i));
  end
endmodule

// File: rtl/tmr_chan_regs.sv
module tmr_chan_regs
  import tmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  acc_t              cfg_acc,
  input  logic [MODE_W-1:0] cfg_mode,
  input  logic              cfg_bcd,
  input  logic              cnt_lat,
  input  logic              st_lat,
  input  logic              data_we,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              rd_sel,
  input  logic [CNT_W-1:0]  live,
  input  logic              out_lvl,
  output logic              load_stb,
  output logic [CNT_W-1:0]  load_val,
  output logic [MODE_W-1:0] mode,
  output logic              bcd,
  output logic [BYTE_W-1:0] rd_byte
);
  acc_t              acc;
  acc_t              lat_st;     // ACC_LATCH means no count snapshot held
  logic              wr_hi;
  logic              rd_hi;
  logic [BYTE_W-1:0] hold;
  logic [CNT_W-1:0]  lat_cnt;
  logic              st_pend;
  logic [BYTE_W-1:0] st_byte;

  always_comb begin
    if (st_pend) begin
      rd_byte = st_byte;
    end else if (lat_st != ACC_LATCH) begin
      rd_byte = (lat_st == ACC_HI) ? lat_cnt[15:8] : lat_cnt[7:0];
    end else begin
      unique case (acc)
        ACC_HI:   rd_byte = live[15:8];
        ACC_WORD: rd_byte = rd_hi ? live[15:8] : live[7:0];
        default:  rd_byte = live[7:0];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc      <= ACC_WORD;
      mode     <= '0;
      bcd      <= 1'b0;
      wr_hi    <= 1'b0;
      rd_hi    <= 1'b0;
      hold     <= '0;
      lat_st   <= ACC_LATCH;
      lat_cnt  <= '0;
      st_pend  <= 1'b0;
      st_byte  <= '0;
      load_stb <= 1'b0;
      load_val <= '0;
    end else begin
      load_stb <= 1'b0;
      if (cfg_we) begin
        acc   <= cfg_acc;
        mode  <= cfg_mode;
        bcd   <= cfg_bcd;
        wr_hi <= 1'b0;
        rd_hi <= 1'b0;
      end
      if (cnt_lat && (lat_st == ACC_LATCH)) begin
        lat_cnt <= live;
        lat_st  <= acc;
      end
      if (st_lat && !st_pend) begin
        st_byte <= {out_lvl, 1'b0, acc, mode, bcd};
        st_pend <= 1'b1;
      end
      if (data_we) begin
        unique case (acc)
          ACC_HI: begin
            load_val <= {wdata, 8'h00};
            load_stb <= 1'b1;
          end
          ACC_WORD: begin
            if (wr_hi) begin
              load_val <= {wdata, hold};
              load_stb <= 1'b1;
            end else begin
              hold <= wdata;
            end
            wr_hi <= !wr_hi;
          end
          default: begin
            load_val <= {8'h00, wdata};
            load_stb <= 1'b1;
          end
        endcase
      end
      if (rd_sel) begin
        if (st_pend) begin
          st_pend <= 1'b0;
        end else if (lat_st != ACC_LATCH) begin
          lat_st <= (lat_st == ACC_WORD) ? ACC_HI : ACC_LATCH;
        end else if (acc == ACC_WORD) begin
          rd_hi <= !rd_hi;
        end
      end
    end
  end
endmodule

// File: rtl/tmr_host_if.sv
module tmr_host_if
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [AW-1:0]         addr,
  input  logic                  wr_en,
  input  logic                  rd_en,
  input  logic [BYTE_W-1:0]     wdata,
  output logic [BYTE_W-1:0]     rdata,
  output logic [NCH-1:0]        load_stb,
  output logic [NCH*CNT_W-1:0]  load_val,
  output logic [NCH*MODE_W-1:0] mode_o,
  output logic [NCH-1:0]        bcd_o,
  input  logic [NCH*CNT_W-1:0]  live_cnt,
  input  logic [NCH-1:0]        ch_out
);
  logic [NCH-1:0]    cfg_we, cnt_lat, st_lat, data_we, rd_sel;
  acc_t              cfg_acc;
  logic [MODE_W-1:0] cfg_mode;
  logic              cfg_bcd;
  logic [BYTE_W-1:0] rd_bytes [NCH];
  logic              rd_go;

  assign rd_go = rd_en && !wr_en;

  tmr_ctrl_decode #(.NCH(NCH), .AW(AW)) u_dec (
    .addr(addr), .wr_en(wr_en), .wdata(wdata),
    .cfg_we(cfg_we), .cnt_lat(cnt_lat), .st_lat(st_lat), .data_we(data_we),
    .cfg_acc(cfg_acc), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign rd_sel[i] = rd_go && (addr == AW'(i));
    tmr_chan_regs u_ch (
      .clk(clk), .rst(rst),
      .cfg_we(cfg_we[i]), .cfg_acc(cfg_acc), .cfg_mode(cfg_mode), .cfg_bcd(cfg_bcd),
      .cnt_lat(cnt_lat[i]), .st_lat(st_lat[i]), .data_we(data_we[i]),
      .wdata(wdata), .rd_sel(rd_sel[i]),
      .live(live_cnt[i*CNT_W +: CNT_W]), .out_lvl(ch_out[i]),
      .load_stb(load_stb[i]), .load_val(load_val[i*CNT_W +: CNT_W]),
      .mode(mode_o[i*MODE_W +: MODE_W]), .bcd(bcd_o[i]),
      .rd_byte(rd_bytes[i])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (rd_go) begin
      rdata <= (int'(addr) < NCH) ? rd_bytes[addr] : '0;
    end
  end
endmodule

// File: rtl/tmr_host_if_chk.sv
module tmr_host_if_chk
  import tmr_pkg::*;
#(
  parameter int NCH = 3,
  parameter int AW  = 2
) (
  input logic                  clk,
  input logic                  rst,
  input logic [AW-1:0]         addr,
  input logic                  wr_en,
  input logic                  rd_en,
  input logic [BYTE_W-1:0]     rdata,
  input logic [NCH-1:0]        load_stb,
  input logic [NCH*MODE_W-1:0] mode_o
);
  a_r3_single_stb: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load_stb));

  a_r2_mode_needs_ctrl: assert property (@(posedge clk) disable iff (rst)
    (mode_o != $past(mode_o)) |-> $past(wr_en && addr == AW'(NCH)));

  a_r11_ctrl_read_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_en && !wr_en && addr == AW'(NCH)) |=> (rdata == '0));

  for (genvar i = 0; i < NCH; i++) begin : g_a
    a_r3_stb_follows_write: assert property (@(posedge clk) disable iff (rst)
      load_stb[i] |-> $past(wr_en && addr == AW'(i)));
    a_r2_mode_folded: assert property (@(posedge clk) disable iff (rst)
      mode_o[i*MODE_W +: MODE_W] <= 3'd5);
  end
endmodule

bind tmr_host_if tmr_host_if_chk #(.NCH(NCH), .AW(AW)) u_chk (.*);

// File: tb/tmr_host_if_test.sv
module tmr_host_if_test;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst = 1;
  logic [1:0]  addr = 0;
  logic        wr_en = 0, rd_en = 0;
  logic [7:0]  wdata = 0;
  logic [7:0]  rdata;
  logic [2:0]  load_stb;
  logic [47:0] load_val;
  logic [8:0]  mode_o;
  logic [2:0]  bcd_o;
  logic [47:0] live_cnt = {16'h5A0F, 16'hABCD, 16'h1234};
  logic [2:0]  ch_out = 3'b101;

  int n_chk = 0, n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  tmr_host_if uut (.*);

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd_en = 1;
    @(negedge clk); rd_en = 0; d = rdata;
  endtask

  task automatic rd_chk(input string req, input logic [1:0] a, input logic [7:0] e);
    logic [7:0] d;
    rd(a, d);
    chk(req, {8'h0, d}, {8'h0, e});
  endtask

  task automatic t_reset;
    chk("R1 mode", {7'h0, mode_o}, 16'h0);
    chk("R1 bcd", {13'h0, bcd_o}, 16'h0);
    chk("R1 stb", {13'h0, load_stb}, 16'h0);
    chk("R1 rdata", {8'h0, rdata}, 16'h0);
    rd_chk("R10 word low", 2'd0, 8'h34);
    rd_chk("R10 word high", 2'd0, 8'h12);
    rd_chk("R10 word low again", 2'd0, 8'h34);
  endtask

  task automatic t_ctrl;
    wr(3, 8'h5D);  // ch1 low-only, mode 6, bcd
    chk("R2 mode6->2", {13'h0, mode_o[5:3]}, 16'd2);
    chk("R2 bcd", {15'h0, bcd_o[1]}, 16'd1);
    wr(3, 8'h9E);  // ch2 low-only, mode 7
    chk("R2 mode7->3", {13'h0, mode_o[8:6]}, 16'd3);
    chk("R2 ch0 untouched", {13'h0, mode_o[2:0]}, 16'd0);
  endtask

  task automatic t_write;
    wr(1, 8'h77);
    chk("R3 lo stb", {13'h0, load_stb}, 16'b010);
    chk("R3 lo val", load_val[31:16], 16'h0077);
    @(negedge clk);
    chk("R3 stb one cycle", {13'h0, load_stb}, 16'h0);
    wr(3, 8'h20);  // ch0 high-only, mode 0
    wr(0, 8'h55);
    chk("R3 hi val", load_val[15:0], 16'h5500);
    rd_chk("R10 high-only repeat", 2'd0, 8'h12);
    rd_chk("R10 high-only repeat 2", 2'd0, 8'h12);
  endtask

  task automatic t_word;
    wr(3, 8'hB0);  // ch2 word, mode 0
    wr(2, 8'h11);
    chk("R4 first byte no load", {13'h0, load_stb}, 16'h0);
    wr(2, 8'h22);
    chk("R4 pair stb", {13'h0, load_stb}, 16'b100);
    chk("R4 pair val", load_val[47:32], 16'h2211);
    wr(2, 8'h33);
    chk("R4 third no load", {13'h0, load_stb}, 16'h0);
    wr(2, 8'h44);
    chk("R4 second pair", load_val[47:32], 16'h4433);
  endtask

  task automatic t_seq_reset;
    wr(2, 8'h99);
    wr(3, 8'hB0);
    wr(2, 8'h01);
    chk("R5 write restarts low", {13'h0, load_stb}, 16'h0);
    wr(2, 8'h02);
    chk("R5 write pair", load_val[47:32], 16'h0201);
    rd_chk("R5 read low", 2'd2, 8'h0F);
    wr(3, 8'hB0);
    rd_chk("R5 read restarts low", 2'd2, 8'h0F);
  endtask

  task automatic t_latch;
    wr(3, 8'h80);  // latch ch2 (word)
    live_cnt[47:32] = 16'h6666;
    rd_chk("R6 frozen low", 2'd2, 8'h0F);
    wr(3, 8'h80);  // ignored: snapshot pending
    rd_chk("R7 frozen high kept", 2'd2, 8'h5A);
    rd_chk("R6 released live", 2'd2, 8'h66);
    wr(3, 8'h00);  // latch ch0 (high-only)
    live_cnt[15:0] = 16'h4321;
    rd_chk("R6 frozen high-only", 2'd0, 8'h12);
    rd_chk("R6 released after one", 2'd0, 8'h43);
  endtask

  task automatic t_multi;
    wr(3, 8'hC6);  // count+status ch0, ch1
    live_cnt[31:16] = 16'h0F0E;
    rd_chk("R9 status ch0 first", 2'd0, 8'hA0);
    rd_chk("R8 count ch0", 2'd0, 8'h43);
    rd_chk("R9 status ch1", 2'd1, 8'h15);
    rd_chk("R8 count ch1 frozen", 2'd1, 8'hCD);
    rd_chk("R8 ch1 released", 2'd1, 8'h0E);
    wr(3, 8'hB0);
    wr(3, 8'hE8);  // status only ch2
    ch_out = 3'b000;
    wr(3, 8'hE8);  // ignored: status pending
    rd_chk("R7 status kept", 2'd2, 8'hB0);
    rd_chk("R8 no count frozen", 2'd2, 8'h66);
    rd_chk("R11 ctrl read", 2'd3, 8'h00);
  endtask

  initial begin
    #(CLK_P * 100000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_ctrl();
    t_write();
    t_word();
    t_seq_reset();
    t_latch();
    t_multi();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule